// File: doc/BRIEF.md
# Infrared Input Conditioning Filter

This block cleans up the single-bit output of an infrared receiver before any pulse-width timing is applied to it. The raw pin is first brought into the clock domain by a two-stage synchronizer. An optional inversion then gives the rest of the chain one fixed polarity. The level is sampled on a strobe derived from the peripheral clock through a power-of-two divider.

A run-length debounce filter moves its output level only after a chosen number of identical consecutive samples: one sample when filtering is off, or two, three or four samples. Every change of the filtered level is also reported as a one-cycle rising or falling pulse. A status bit keeps a copy of the filtered level for as long as a store-enable input is high.

The block is disabled by dropping its enable. This restarts the divider, forgets the sample history and parks the output at its idle level. A pulse timer or decoder downstream uses the filtered level and the edge pulses.

Top module: `ir_input_filter`

## Requirements
- R1: During and right after reset, `level_o` equals the idle level (parameter `IDLE_LVL`, default 1), `rise_o` and `fall_o` are 0 and `stat_o` is 0.
- R2: The pin value seen by the filter at a clock edge is the value `pin_i` had at the clock edge two cycles earlier (two synchronizer stages).
- R3: With prescaler code n on `psc_i`, a sample is taken every 2^n clock edges. The first sample comes at the 2^n-th edge at which `en_i` is 1, so code 0 samples at every edge and code 7 at every 128th edge. For codes above 0, a sample strobe never lasts two consecutive cycles.
- R4: When `inv_i` is 1, the synchronized pin is inverted before it is sampled. When `inv_i` is 0, it passes unchanged.
- R5: With debounce code c on `dbc_i` (0 to 3), `level_o` takes a new sample value once the last c+1 samples, this one included, all carry that value. Code 0 therefore follows every sample, and `level_o` changes at no other edge.
- R6: `rise_o` (or `fall_o`) is 1 for exactly the cycle in which `level_o` has just gone from 0 to 1 (or from 1 to 0) because of a sample. They are never both 1.
- R7: At each edge where `stat_en_i` is 1, `stat_o` takes the `level_o` value held before that edge. While `stat_en_i` is 0, `stat_o` holds its value.
- R8: At an edge where `en_i` is 0, `level_o` returns to the idle level without an edge pulse, the divider restarts and the sample history is emptied.
- R9: At an edge where `dbc_i` differs from its value at the previous edge, the sample history is emptied, and a sample that falls on that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw receiver pin, asynchronous |
| en_i | input | 1 | Block enable |
| inv_i | input | 1 | Input polarity inversion |
| psc_i | input | 3 | Sample divider code, period 2^code clocks |
| dbc_i | input | 2 | Debounce code, 0 off, 1..3 need 2..4 equal samples |
| stat_en_i | input | 1 | Store-enable for the status copy |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle pulse on a 0-to-1 filtered change |
| fall_o | output | 1 | One-cycle pulse on a 1-to-0 filtered change |
| stat_o | output | 1 | Status copy of the filtered level |

## Verification
Two cases can land in the same cycle. A debounce-code change can coincide with a sample strobe, which would otherwise complete a run. A store-enable edge can coincide with a filtered-level change. The bench changes `dbc_i` in the middle of an enabled run and toggles `stat_en_i` on a period unrelated to the pin pattern, so both coincidences occur across the sweep. A cycle-level model built from the requirements judges them: the sample on a code-change edge is discarded, and the status copy takes the level from before the change.

// File: rtl/irf_pkg.sv
package irf_pkg;
  localparam int PSC_W       = 3;
  localparam int DBC_W       = 2;
  localparam int SYNC_STAGES = 2;
  localparam int RUN_MAX     = 1 << DBC_W;
  localparam int RUN_W       = $clog2(RUN_MAX + 1);
  localparam int DIV_W       = (1 << PSC_W) - 1;

  typedef logic [PSC_W-1:0] psc_code_t;
  typedef logic [DBC_W-1:0] dbc_code_t;
  typedef logic [RUN_W-1:0] run_t;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } filt_out_t;
endpackage

// File: rtl/irf_sync.sv
module irf_sync #(
  parameter int STAGES = irf_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irf_strobe.sv
module irf_strobe #(
  parameter int PSC_W = irf_pkg::PSC_W,
  localparam int DIV_W = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] last_val;

  // terminal count 2^code - 1 as a thermometer mask
  always_comb begin
    for (int i = 0; i < DIV_W; i++) last_val[i] = (i < int'(psc_i));
  end

  assign stb_o = en_i && (cnt_q >= last_val);

  always_comb begin
    if (!en_i)      cnt_d = '0;
    else if (stb_o) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irf_debounce.sv
module irf_debounce #(
  parameter int   DBC_W    = irf_pkg::DBC_W,
  parameter logic IDLE_LVL = 1'b1,
  localparam int  RUN_MAX  = 1 << DBC_W,
  localparam int  RUN_W    = $clog2(RUN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             smp_i,
  input  logic [DBC_W-1:0] dbc_i,
  output irf_pkg::filt_out_t out_o
);
  logic [DBC_W-1:0] dbc_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             last_q, last_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             clr;
  logic             take;
  logic [RUN_W-1:0] need;

  assign clr  = (dbc_i != dbc_q);
  assign need = RUN_W'(dbc_i) + RUN_W'(1);

  always_comb begin
    run_d  = run_q;
    last_d = last_q;
    if (!en_i || clr) begin
      run_d = '0;
    end else if (stb_i) begin
      last_d = smp_i;
      if (run_q != '0 && smp_i == last_q)
        run_d = (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + 1'b1;
      else
        run_d = RUN_W'(1);
    end
  end

  assign take = en_i && !clr && stb_i && (run_d >= need) && (smp_i != lvl_q);

  always_comb begin
    rise_d = 1'b0;
    fall_d = 1'b0;
    lvl_d  = lvl_q;
    if (!en_i) begin
      lvl_d = IDLE_LVL;
    end else if (take) begin
      lvl_d  = smp_i;
      rise_d = smp_i;
      fall_d = !smp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbc_q  <= '0;
      run_q  <= '0;
      last_q <= 1'b0;
      lvl_q  <= IDLE_LVL;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      dbc_q  <= dbc_i;
      run_q  <= run_d;
      last_q <= last_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign out_o.level = lvl_q;
  assign out_o.rise  = rise_q;
  assign out_o.fall  = fall_q;
endmodule

// File: rtl/ir_input_filter.sv
module ir_input_filter #(
  parameter logic IDLE_LVL = 1'b1,
  parameter int   PSC_W    = irf_pkg::PSC_W,
  parameter int   DBC_W    = irf_pkg::DBC_W,
  parameter int   STAGES   = irf_pkg::SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [DBC_W-1:0] dbc_i,
  input  logic             stat_en_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             stat_o
);
  logic               pin_sync;
  logic               smp;
  logic               smp_stb;
  irf_pkg::filt_out_t filt;
  logic               stat_q, stat_d;

  irf_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign smp = pin_sync ^ inv_i;

  irf_strobe #(.PSC_W(PSC_W)) u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .psc_i (psc_i),
    .stb_o (smp_stb)
  );

  irf_debounce #(.DBC_W(DBC_W), .IDLE_LVL(IDLE_LVL)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .stb_i (smp_stb),
    .smp_i (smp),
    .dbc_i (dbc_i),
    .out_o (filt)
  );

  assign stat_d = stat_en_i ? filt.level : stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= stat_d;
  end

  assign level_o = filt.level;
  assign rise_o  = filt.rise;
  assign fall_o  = filt.fall;
  assign stat_o  = stat_q;
endmodule

// File: rtl/ir_input_filter_chk.sv
module ir_input_filter_chk #(
  parameter logic IDLE_LVL = 1'b1,
  parameter int   PSC_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PSC_W-1:0] psc_i,
  input logic             stb,
  input logic             stat_en_i,
  input logic             level_o,
  input logic             rise_o,
  input logic             fall_o,
  input logic             stat_o
);
  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && psc_i != '0) |=> (!stb || psc_i != $past(psc_i)));

  // R5
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stb) |=> $stable(level_o));

  // R6
  rise_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (level_o && !$past(level_o) && !fall_o));

  // R6
  fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!level_o && $past(level_o)));

  // R7
  stat_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_en_i |=> (stat_o == $past(level_o)));

  // R7
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_en_i |=> $stable(stat_o));

  // R8
  idle_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (level_o == IDLE_LVL && !rise_o && !fall_o));
endmodule

bind ir_input_filter ir_input_filter_chk #(.IDLE_LVL(IDLE_LVL), .PSC_W(PSC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .psc_i    (psc_i),
  .stb      (smp_stb),
  .stat_en_i(stat_en_i),
  .level_o  (level_o),
  .rise_o   (rise_o),
  .fall_o   (fall_o),
  .stat_o   (stat_o)
);

// File: tb/ir_input_filter_tb_top.sv
module ir_input_filter_tb_top;
  localparam logic IDLE = 1'b1;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       pin_i, en_i, inv_i, stat_en_i;
  logic [2:0] psc_i;
  logic [1:0] dbc_i;
  logic       level_o, rise_o, fall_o, stat_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk_i = ~clk_i;

  ir_input_filter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .en_i(en_i), .inv_i(inv_i),
    .psc_i(psc_i), .dbc_i(dbc_i), .stat_en_i(stat_en_i),
    .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o), .stat_o(stat_o)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_lvl, m_rise, m_fall, m_stat, m_last;
  logic [1:0] m_dbc;
  int   m_k, m_run;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_lvl = IDLE; m_rise = 1'b0; m_fall = 1'b0;
      m_stat = 1'b0; m_last = 1'b0; m_dbc = 2'd0; m_k = 0; m_run = 0;
    end else begin
      logic smp, stb, clr;
      int   per;
      smp = m_s2 ^ inv_i;                 // R2 two edges late, R4 inversion
      m_s2 = m_s1; m_s1 = pin_i;
      m_stat = stat_en_i ? m_lvl : m_stat; // R7
      m_rise = 1'b0; m_fall = 1'b0;
      clr = (dbc_i != m_dbc); m_dbc = dbc_i;
      per = 1 << psc_i;
      if (!en_i) begin                      // R8
        m_k = 0; m_run = 0; m_lvl = IDLE;
      end else begin
        stb = ((m_k % per) == per - 1);     // R3
        m_k++;
        if (clr) m_run = 0;                 // R9
        else if (stb) begin                 // R5
          if (m_run != 0 && smp == m_last) m_run = (m_run < 4) ? m_run + 1 : 4;
          else m_run = 1;
          m_last = smp;
          if (m_run >= int'(dbc_i) + 1 && smp != m_lvl) begin
            m_rise = smp; m_fall = !smp; m_lvl = smp;
          end
        end
      end
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      check1("R2,R3,R4,R5,R8,R9 level", level_o, m_lvl);
      check1("R6 rise", rise_o, m_rise);
      check1("R6 fall", fall_o, m_fall);
      check1("R7 status", stat_o, m_stat);
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_cfg(input int psc, input int dbc, input bit inv, input int ncyc,
                         input int dbc_alt);
    int left = 0;
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check1("R8 parked", level_o, IDLE);
    psc_i = 3'(psc); dbc_i = 2'(dbc); inv_i = inv;
    @(negedge clk_i);
    en_i = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      if (left == 0) begin
        lfsr = step(lfsr);
        pin_i = ~pin_i;
        left = 1 + int'(lfsr[9:0]) % (5 * (1 << psc));
      end
      left--;
      if (c % 37 == 0) stat_en_i = ~stat_en_i;
      if (dbc_alt >= 0 && c == ncyc / 2) dbc_i = 2'(dbc_alt);          // R9
      if (dbc_alt >= 0 && c == ncyc / 2 + 3 * (1 << psc)) dbc_i = 2'(dbc);
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; pin_i = 1'b1; en_i = 1'b0; inv_i = 1'b0; stat_en_i = 1'b0;
    psc_i = 3'd0; dbc_i = 2'd0;
    repeat (3) @(negedge clk_i);
    check1("R1 level", level_o, IDLE);
    check1("R1 rise", rise_o, 1'b0);
    check1("R1 fall", fall_o, 1'b0);
    check1("R1 status", stat_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check1("R1 level after release", level_o, IDLE);
    cmp_on = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int d = 0; d < 4; d++)
        for (int v = 0; v < 2; v++)
          run_cfg(p, d, v[0], 400, -1);
    run_cfg(1, 3, 1'b0, 600, 1);   // R9 code change mid-run
    run_cfg(2, 0, 1'b1, 800, 3);   // R9 code change mid-run
    run_cfg(7, 2, 1'b0, 3000, -1); // R3 largest divider
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check1("R8 final park", level_o, IDLE);
    finish_run();
  end
endmodule